// File: doc/BRIEF.md
# Pipeline Interlock and Forwarding Controller

This block sequences an in-order five-stage pipeline (fetch, decode, execute, memory, writeback) at the level of occupancy and timing. It does not compute results. Each instruction arrives on a valid/ready input and carries a one-bit opcode and one flag. The opcode selects a single-cycle add or a two-cycle multiply in execute. The flag says the instruction consumes the result of the instruction just ahead of it. Operands are read when an instruction enters execute, so every data hazard is resolved at that boundary.

A static mode input selects whether results are forwarded. With forwarding, a consumer may enter execute as soon as its producer leaves execute. Without forwarding, it must wait until the producer has finished writeback. While an instruction is held in decode, the fetch stage holds as well, and empty slots flow down into execute. The block reports which stages are occupied, a per-cycle stall flag, a cycle count that freezes on the final writeback, and a completion flag. The block can be used to measure how long an instruction mix takes under either mode.

Top module: `hazard_pipe`

## Requirements
- R1: While reset is high and in the first cycle after it drops, every stage is empty, `cycleCount` is 0, `done` is 0 and `inReady` is 1.
- R2: An add (`inOp`=0) spends one cycle in execute and a multiply (`inOp`=1) spends two. Every other stage takes one cycle. An unhindered instruction reaches writeback four cycles after fetch for an add and five cycles after fetch for a multiply. `stageBusy` bit 0 is fetch, bit 1 decode, bit 2 execute, bit 3 memory and bit 4 writeback.
- R3: With `fwdEn`=0, an instruction marked dependent (`inDep`=1) enters execute no earlier than the cycle after its predecessor's writeback cycle. For the alternating add/multiply program of eight instructions, with every instruction after the first dependent, the last writeback occurs in cycle 30.
- R4: With `fwdEn`=1, a dependent instruction may enter execute in the cycle right after its predecessor's last execute cycle. For the same eight-instruction program, the last writeback occurs in cycle 16.
- R5: `stall` is high in exactly the cycles in which decode holds an instruction that cannot enter execute. In those cycles, decode and fetch keep their contents.
- R6: `inReady` is high only when the fetch stage can take an instruction at the coming edge. An instruction is accepted when `inValid` and `inReady` are both high.
- R7: `cycleCount` becomes 1 in the cycle that follows the first acceptance after reset. It then advances by one each cycle, so during the writeback cycle of any instruction it equals that cycle's number. It stops at the cycle number of the writeback of the instruction marked `inLast`, and `done` rises one cycle later. Both then hold until reset.
- R8: Instructions with `inDep`=0 wait only for a free stage. Their timing is the same with `fwdEn`=0 and `fwdEn`=1.
- R9: After an instruction marked `inLast` is accepted, `inReady` stays low until reset.
- R10: While `inValid` is low, nothing enters fetch and no stage becomes occupied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fwdEn | input | 1 | 1 enables result forwarding. Held static between resets |
| inValid | input | 1 | An instruction is offered |
| inOp | input | 1 | 0 = add, 1 = multiply |
| inDep | input | 1 | Instruction uses the result of its predecessor |
| inLast | input | 1 | Instruction is the final one of the program |
| inReady | output | 1 | Fetch can take the offered instruction |
| stageBusy | output | 5 | Occupancy: bit 0 fetch through bit 4 writeback |
| stall | output | 1 | Decode is holding an instruction this cycle |
| cycleCount | output | CNT_W | Cycles since first fetch; frozen at the last writeback |
| done | output | 1 | The program has fully retired |

## Verification
Two kinds of internal fault show up at the ports: a wrong execute countdown and a wrong hazard decision. Either one moves the writeback cycle of the affected instruction and of every instruction after it. The scoreboard therefore flags the fault at the first writeback that is off schedule, and `stall` no longer sums to the number of held decode cycles. A counter or completion fault shows up as a `cycleCount` that disagrees with the writeback cycle in which it is sampled, or as `done` rising a cycle early or late. A lost end-of-program marker leaves `inReady` high after the last instruction has been accepted.

// File: rtl/hazard_pkg.sv
package hazard_pkg;

  typedef enum logic {
    OP_ADD = 1'b0,
    OP_MUL = 1'b1
  } opKind_t;

  // Contents of a front-end stage slot (fetch or decode).
  typedef struct packed {
    logic    valid;
    opKind_t op;
    logic    dep;
    logic    last;
  } slot_t;

  // Strobes issued by the control each cycle to the stage registers.
  typedef struct packed {
    logic ifLoad;   // capture the offered instruction into fetch
    logic ifGo;     // fetch -> decode
    logic idGo;     // decode -> execute
    logic exDone;   // execute -> memory (final execute cycle)
  } strobe_t;

  localparam int ST_IF  = 0;
  localparam int ST_ID  = 1;
  localparam int ST_EX  = 2;
  localparam int ST_MEM = 3;
  localparam int ST_WB  = 4;
  localparam int NUM_ST = 5;

endpackage

// File: rtl/hazard_ctrl.sv
module hazard_ctrl
  import hazard_pkg::*;
#(
  parameter int LEFT_W = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fwdEn,
  input  logic              inValid,
  input  logic              inLast,
  input  logic              ifBusy,
  input  logic              idBusy,
  input  logic              idDep,
  input  logic              exBusy,
  input  logic              memBusy,
  input  logic [LEFT_W-1:0] exLeft,
  output strobe_t           stb,
  output logic              inReady,
  output logic              stall
);

  logic endSeen;
  logic exDone, exFree, dataWait, idGo, idFree, ifGo, ifFree, ifLoad;

  // Execute releases its slot on its last cycle.
  assign exDone = exBusy && (exLeft == '0);
  assign exFree = !exBusy || exDone;

  // Without forwarding the producer (the youngest instruction ahead)
  // must have reached writeback; with forwarding leaving execute is enough,
  // which the structural check already covers.
  assign dataWait = idBusy && idDep && !fwdEn && (exBusy || memBusy);

  assign idGo   = idBusy && exFree && !dataWait;
  assign idFree = !idBusy || idGo;
  assign ifGo   = ifBusy && idFree;
  assign ifFree = !ifBusy || ifGo;

  assign inReady = ifFree && !endSeen;
  assign ifLoad  = inValid && inReady;
  assign stall   = idBusy && !idGo;

  assign stb = '{ifLoad: ifLoad, ifGo: ifGo, idGo: idGo, exDone: exDone};

  always_ff @(posedge clk) begin
    if (rst) begin
      endSeen <= 1'b0;
    end else if (ifLoad && inLast) begin
      endSeen <= 1'b1;
    end
  end

  // R9: once the final instruction is taken, the input stays closed.
  a_r9_closed_after_last : assert property (@(posedge clk) disable iff (rst)
    (inValid && inReady && inLast) |=> !inReady);

endmodule

// File: rtl/hazard_stages.sv
module hazard_stages
  import hazard_pkg::*;
#(
  parameter int ADD_CYC = 1,
  parameter int MUL_CYC = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                fwdEn,
  input  strobe_t             stb,
  input  logic                inOp,
  input  logic                inDep,
  input  logic                inLast,
  output logic [NUM_ST-1:0]   busy,
  output logic                idDep,
  output logic [LEFT_W-1:0]   exLeft,
  output logic                lastRetire
);

  localparam int MAX_CYC = (ADD_CYC > MUL_CYC) ? ADD_CYC : MUL_CYC;
  localparam int LEFT_W  = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;
  localparam logic [LEFT_W-1:0] ADD_LEFT = LEFT_W'(ADD_CYC - 1);
  localparam logic [LEFT_W-1:0] MUL_LEFT = LEFT_W'(MUL_CYC - 1);

  slot_t ifS, idS;
  logic  exValid, exLast;
  logic  memValid, memLast;
  logic  wbValid, wbLast;
  logic  [LEFT_W-1:0] exLeftQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      ifS      <= '0;
      idS      <= '0;
      exValid  <= 1'b0;
      exLast   <= 1'b0;
      exLeftQ  <= '0;
      memValid <= 1'b0;
      memLast  <= 1'b0;
      wbValid  <= 1'b0;
      wbLast   <= 1'b0;
    end else begin
      // fetch
      if (stb.ifLoad) begin
        ifS <= '{valid: 1'b1, op: opKind_t'(inOp), dep: inDep, last: inLast};
      end else if (stb.ifGo) begin
        ifS.valid <= 1'b0;
      end
      // decode
      if (stb.ifGo) begin
        idS <= ifS;
      end else if (stb.idGo) begin
        idS.valid <= 1'b0;
      end
      // execute: countdown of remaining cycles after the current one
      if (stb.idGo) begin
        exValid <= 1'b1;
        exLast  <= idS.last;
        exLeftQ <= (idS.op == OP_MUL) ? MUL_LEFT : ADD_LEFT;
      end else if (stb.exDone) begin
        exValid <= 1'b0;
      end else if (exValid) begin
        exLeftQ <= exLeftQ - 1'b1;
      end
      // memory and writeback advance every cycle
      memValid <= stb.exDone;
      memLast  <= stb.exDone && exLast;
      wbValid  <= memValid;
      wbLast   <= memValid && memLast;
    end
  end

  logic [NUM_ST-1:0] occ;
  assign occ[ST_IF]  = ifS.valid;
  assign occ[ST_ID]  = idS.valid;
  assign occ[ST_EX]  = exValid;
  assign occ[ST_MEM] = memValid;
  assign occ[ST_WB]  = wbValid;

  for (genvar g = 0; g < NUM_ST; g++) begin : g_occ
    assign busy[g] = occ[g];
  end

  assign idDep      = idS.dep;
  assign exLeft     = exLeftQ;
  assign lastRetire = wbValid && wbLast;

  // R5: a held decode slot keeps its instruction into the next cycle.
  a_r5_decode_hold : assert property (@(posedge clk) disable iff (rst)
    (idS.valid && !stb.idGo) |=> (idS.valid && idS == $past(idS)));

  // R2: a multi-cycle execute counts down by one per cycle without leaving.
  a_r2_ex_countdown : assert property (@(posedge clk) disable iff (rst)
    (exValid && exLeftQ != '0) |=> (exValid && (exLeftQ + 1'b1) == $past(exLeftQ)));

  // R3: without forwarding a consumer enters execute behind an empty back end.
  a_r3_wait_writeback : assert property (@(posedge clk) disable iff (rst)
    (stb.idGo && idS.dep && !fwdEn) |=> (!memValid && !wbValid));

endmodule

// File: rtl/hazard_tally.sv
module hazard_tally #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             accept,
  input  logic             lastRetire,
  output logic [CNT_W-1:0] cycleCount,
  output logic             done
);

  logic started;

  always_ff @(posedge clk) begin
    if (rst) begin
      started    <= 1'b0;
      cycleCount <= '0;
      done       <= 1'b0;
    end else if (!started) begin
      if (accept) begin
        started    <= 1'b1;
        cycleCount <= CNT_W'(1);
      end
    end else if (!done) begin
      if (lastRetire) begin
        done <= 1'b1;
      end else begin
        cycleCount <= cycleCount + 1'b1;
      end
    end
  end

  // R7: after completion both the count and the flag are frozen.
  a_r7_freeze : assert property (@(posedge clk) disable iff (rst)
    done |=> (done && $stable(cycleCount)));

endmodule

// File: rtl/hazard_pipe.sv
module hazard_pipe
  import hazard_pkg::*;
#(
  parameter int ADD_CYC = 1,
  parameter int MUL_CYC = 2,
  parameter int CNT_W   = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fwdEn,
  input  logic             inValid,
  input  logic             inOp,
  input  logic             inDep,
  input  logic             inLast,
  output logic             inReady,
  output logic [4:0]       stageBusy,
  output logic             stall,
  output logic [CNT_W-1:0] cycleCount,
  output logic             done
);

  localparam int MAX_CYC = (ADD_CYC > MUL_CYC) ? ADD_CYC : MUL_CYC;
  localparam int LEFT_W  = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;

  strobe_t           stb;
  logic [NUM_ST-1:0] busy;
  logic              idDep, lastRetire;
  logic [LEFT_W-1:0] exLeft;

  hazard_ctrl #(.LEFT_W(LEFT_W)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .fwdEn   (fwdEn),
    .inValid (inValid),
    .inLast  (inLast),
    .ifBusy  (busy[ST_IF]),
    .idBusy  (busy[ST_ID]),
    .idDep   (idDep),
    .exBusy  (busy[ST_EX]),
    .memBusy (busy[ST_MEM]),
    .exLeft  (exLeft),
    .stb     (stb),
    .inReady (inReady),
    .stall   (stall)
  );

  hazard_stages #(.ADD_CYC(ADD_CYC), .MUL_CYC(MUL_CYC)) u_stages (
    .clk        (clk),
    .rst        (rst),
    .fwdEn      (fwdEn),
    .stb        (stb),
    .inOp       (inOp),
    .inDep      (inDep),
    .inLast     (inLast),
    .busy       (busy),
    .idDep      (idDep),
    .exLeft     (exLeft),
    .lastRetire (lastRetire)
  );

  hazard_tally #(.CNT_W(CNT_W)) u_tally (
    .clk        (clk),
    .rst        (rst),
    .accept     (stb.ifLoad),
    .lastRetire (lastRetire),
    .cycleCount (cycleCount),
    .done       (done)
  );

  assign stageBusy = busy;

endmodule

// File: tb/sim_hazard_pipe.sv
module sim_hazard_pipe;

  logic        clk = 1'b0;
  logic        rst;
  logic        fwdEn, inValid, inOp, inDep, inLast;
  logic        inReady, stall, done;
  logic [4:0]  stageBusy;
  logic [15:0] cycleCount;

  always #2 clk = ~clk;

  hazard_pipe u0 (
    .clk(clk), .rst(rst), .fwdEn(fwdEn), .inValid(inValid), .inOp(inOp),
    .inDep(inDep), .inLast(inLast), .inReady(inReady), .stageBusy(stageBusy),
    .stall(stall), .cycleCount(cycleCount), .done(done)
  );

  int    checks = 0, fails = 0;
  int    rawCyc = 0, base = 0;
  bit    started = 0, running = 0;
  int    expQ[$];
  int    stallSeen, stallExp, lastWbSeen;
  string runTag;

  always @(posedge clk) rawCyc <= rawCyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Monitor: pops the expected writeback cycle for every retirement.
  always @(negedge clk) begin
    if (running && started) begin
      int cyc;
      cyc = rawCyc - base + 1;
      if (stall) stallSeen++;
      if (stageBusy[4]) begin
        if (expQ.size() == 0) begin
          check(0, runTag, "unexpected writeback cycle", cyc, -1);
        end else begin
          int e;
          e = expQ.pop_front();
          check(cyc == e, runTag, "writeback cycle (R2/R6 schedule)", cyc, e);
          check(int'(cycleCount) == cyc, "R7", "count during writeback", int'(cycleCount), cyc);
          check(done == 1'b0, "R7", "done during writeback", done, 0);
          lastWbSeen = cyc;
        end
      end
    end
  end

  task automatic doReset(input bit fwd);
    @(negedge clk);
    rst = 1'b1; inValid = 1'b0; inOp = 1'b0; inDep = 1'b0; inLast = 1'b0; fwdEn = fwd;
    repeat (3) @(negedge clk);
    check(stageBusy == 5'b0 && !done && cycleCount == 16'd0, "R1", "state in reset",
          {stageBusy, done}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(stageBusy == 5'b0 && cycleCount == 16'd0 && !done && inReady, "R1",
          "state after reset", {stageBusy, done, inReady}, 1);
    @(negedge clk);
    check(stageBusy == 5'b0 && cycleCount == 16'd0, "R10", "idle input leaves stages empty",
          int'(stageBusy), 0);
  endtask

  task automatic runProg(input string tag, input bit fwd, input int n,
                         input logic [15:0] ops, input logic [15:0] deps,
                         input int expLast, output int finalCount);
    int ifc, idc, exs, exe, wbc;
    int pId, pExs, pExe, pWb;
    int waitCnt, doneCyc;
    doReset(fwd);
    runTag = tag;
    expQ.delete();
    stallExp = 0; stallSeen = 0; lastWbSeen = 0;
    pId = 0; pExs = 0; pExe = 0; pWb = 0;
    // Independent schedule model built from the requirements.
    for (int i = 0; i < n; i++) begin
      if (i == 0) begin
        ifc = 1; idc = 2; exs = 3;
      end else begin
        ifc = pId;
        idc = (ifc + 1 > pExs) ? ifc + 1 : pExs;
        exs = (idc + 1 > pExe + 1) ? idc + 1 : pExe + 1;
        if (deps[i] && !fwd && exs < pWb + 1) exs = pWb + 1;
      end
      exe = exs + (ops[i] ? 1 : 0);
      wbc = exe + 2;
      stallExp += exs - idc - 1;
      expQ.push_back(wbc);
      pId = idc; pExs = exs; pExe = exe; pWb = wbc;
    end
    if (expLast < 0) expLast = pWb;
    started = 0;
    running = 1;
    // Driver
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inValid = 1'b1; inOp = ops[i]; inDep = deps[i]; inLast = (i == n - 1);
      #1;
      while (!inReady) begin
        @(negedge clk);
        #1;
      end
      @(posedge clk);
      #1;
      if (!started) begin
        base = rawCyc;
        started = 1;
      end
    end
    @(negedge clk);
    inValid = 1'b0; inLast = 1'b0;
    #1;
    check(!inReady, "R9", "ready after final instruction", inReady, 0);
    waitCnt = 0;
    while (!done && waitCnt < 400) begin
      @(negedge clk);
      waitCnt++;
    end
    doneCyc = rawCyc - base + 1;
    check(done == 1'b1, "R7", "done raised", done, 1);
    check(doneCyc == expLast + 1, "R7", "done one cycle after last writeback", doneCyc, expLast + 1);
    check(int'(cycleCount) == expLast, tag, "frozen count equals last writeback",
          int'(cycleCount), expLast);
    check(expQ.size() == 0, tag, "retirements outstanding", expQ.size(), 0);
    check(stallSeen == stallExp, "R5", "stall cycles", stallSeen, stallExp);
    repeat (2) @(negedge clk);
    check(int'(cycleCount) == expLast && done && !inReady, "R7", "count holds after done",
          int'(cycleCount), expLast);
    check(!inReady, "R9", "ready stays low", inReady, 0);
    finalCount = int'(cycleCount);
    running = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int r3Last, r4Last, r8Off, r8On, tmp;
    rst = 1'b1; fwdEn = 1'b0; inValid = 1'b0; inOp = 1'b0; inDep = 1'b0; inLast = 1'b0;
    // Single add: writeback four cycles after fetch (R2).
    runProg("R2", 1'b0, 1, 16'h0000, 16'h0000, 5, tmp);
    // Single multiply: one extra execute cycle (R2).
    runProg("R2", 1'b1, 1, 16'h0001, 16'h0000, 6, tmp);
    // Alternating add/multiply chain, no forwarding (R3).
    runProg("R3", 1'b0, 8, 16'h00AA, 16'h00FE, 30, r3Last);
    check(r3Last == 30, "R3", "chain total without forwarding", r3Last, 30);
    // Same chain with forwarding (R4).
    runProg("R4", 1'b1, 8, 16'h00AA, 16'h00FE, 16, r4Last);
    check(r4Last == 16, "R4", "chain total with forwarding", r4Last, 16);
    // Independent stream in both modes (R8).
    runProg("R8", 1'b0, 8, 16'h00AA, 16'h0000, -1, r8Off);
    runProg("R8", 1'b1, 8, 16'h00AA, 16'h0000, -1, r8On);
    check(r8Off == r8On, "R8", "independent timing equal across modes", r8Off, r8On);
    // Mixed pattern, both modes (R5, R6).
    runProg("R5", 1'b0, 10, 16'h0333, 16'h01AC, -1, tmp);
    runProg("R6", 1'b1, 10, 16'h0333, 16'h01AC, -1, tmp);
    // Back-to-back multiplies, all dependent, no forwarding (R3).
    runProg("R3", 1'b0, 4, 16'h000F, 16'h000F, -1, tmp);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule